// File: doc/BRIEF.md
# Performance Event Counter Bank

This block is a bank of eight 32-bit event counters for a processor core. Each counter has a 5-bit selector that picks what it counts. The options are a pulse from a 16-wide vector of direct events, a single bit from a four-lane byte-wide event bus, or the sum of two paired bits from one lane (adder mode). The selectors for counters 1 and 2 sit in control word 0. The selectors for counters 3 to 8 are packed into control word 1.

A single register port reads and writes the control words and the counters. Reads return data one cycle after the address is presented.

A freeze bit in control word 0 stops every counter. Whenever any counter holds its top bit set, a sticky overflow flag is raised. If the interrupt enable is on, that flag drives the interrupt output, and the interrupt in turn freezes the bank.

Top module: `pmu_bank`

## Requirements
- R1: After reset the bank holds these values:
  - Control word 0 (address 0) reads 0x80000810: freeze set, interrupt enable clear, both selectors 0x08, overflow clear.
  - Control word 1 (address 1) reads 0x42108420, which is 0x08 in all six fields.
  - The adder-enable word (address 2) reads 0.
  - Every counter (addresses 8 to 15 for counters 1 to 8) reads 0.
  - The interrupt is low.
- R2: A counter whose selector is 0x08 never changes. While control word 0 bit 31 (freeze) is set, no counter changes except by a register write.
- R3: Selector 0x0f adds one on every unfrozen cycle. The selector fields are placed as follows:
  - Counter 1 uses control word 0 bits 12:8.
  - Counter 2 uses control word 0 bits 5:1.
  - Counter n (3 to 8) uses control word 1 bits starting at 5*(8-n)+2.
- R4: Selectors 0x01 to 0x07 and 0x09 to 0x0e add one in each cycle where the direct event bit with that index is high. Bit 9 is the completed-instruction pulse.
- R5: A selector with bit 4 set picks a bus bit. Bit 3 picks the lane: clear for the counter's lower lane, set for its upper lane. Bits 2:0 give the bit within the lane. Lane j is bits 8j+7:8j of the bus. Counters 1, 2, 5 and 6 use lane 0 as lower and lane 2 as upper; counters 3, 4, 7 and 8 use lanes 1 and 3.
- R6: Selector 0 with the counter's adder-enable bit set (address 2 bit n-1) adds bits p and p+4 of the counter's lower lane, where p = (n-1) mod 4. It adds 0, 1 or 2 per cycle.
- R7: Selector 0 with the adder-enable bit clear does not count.
- R8: A register write to a counter loads the written value, which wins over any increment in that cycle.
- R9: The overflow flag (control word 0 bit 0) is set in the cycle after any counter holds bit 31. It stays set until a write to address 0 clears it while no counter has bit 31 set. Aside from writes, the overflow set and the interrupt-driven freeze, control word 0 holds its value.
- R10: The interrupt is high in the cycle after the overflow flag and the interrupt enable (control word 0 bit 30) are both set, and low otherwise. A high interrupt sets the freeze bit in the next cycle, over any write.
- R11: Read data is registered and reflects the state before the clock edge that samples the address. Addresses 3 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 16 | Direct event pulses, indexed by selector value |
| bus_lanes | input | 32 | Event bus, four byte lanes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| pm_irq | output | 1 | Overflow interrupt, registered |

## Verification
The bench builds the bank with its default 32-bit counters. Overflow is reached by loading counter 1 a few counts below bit 31 through the register port instead of counting up to it. Random direct events and random bus lanes are applied on every cycle. With these inputs, each selector class, both lane choices for both lane groups, and every adder pair are exercised against a behavioural model. The overflow, interrupt and freeze chain is run both with and without the interrupt enable, including an attempt to clear the flag while a counter still holds its top bit.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CTR   = 8;
  localparam int SEL_W     = 5;
  localparam int NUM_LANES = 4;
  localparam int LANE_W    = 8;
  localparam int INC_W     = 2;
  localparam int REG_W     = 32;
  localparam int DIR_EVT   = 1 << (SEL_W - 1);
  localparam int IDX_W     = $clog2(NUM_CTR);
  localparam int ADDR_W    = IDX_W + 1;

  localparam int C0_FRZ = 31;
  localparam int C0_IE  = 30;
  localparam int C0_OVF = 0;

  localparam logic [SEL_W-1:0] SEL_OFF = 5'h08;
  localparam logic [SEL_W-1:0] SEL_CYC = 5'h0f;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [INC_W-1:0] inc_t;

  // bit position of counter k's (0-based) selector in its control word
  function automatic int sel_pos(int k);
    if (k == 0) return 8;
    else if (k == 1) return 1;
    else return 5 * (NUM_CTR - 1 - k) + 2;
  endfunction

  function automatic logic [REG_W-1:0] ctl1_rst();
    logic [REG_W-1:0] v;
    v = '0;
    for (int k = 2; k < NUM_CTR; k++) v = v | (REG_W'(SEL_OFF) << sel_pos(k));
    return v;
  endfunction

  localparam logic [REG_W-1:0] CTL0_RST = (REG_W'(1) << C0_FRZ)
                                        | (REG_W'(SEL_OFF) << sel_pos(0))
                                        | (REG_W'(SEL_OFF) << sel_pos(1));
  localparam logic [REG_W-1:0] CTL1_RST = ctl1_rst();
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter int CTR_IDX = 0
) (
  input  sel_t                        sel,
  input  logic                        add_en,
  input  logic [DIR_EVT-1:0]          evt,
  input  logic [NUM_LANES*LANE_W-1:0] lanes,
  output inc_t                        inc
);
  localparam int LO_LANE = (CTR_IDX / 2) % 2;
  localparam int HI_LANE = LO_LANE + 2;
  localparam int PAIR    = CTR_IDX % 4;

  logic [LANE_W-1:0] lo_l, hi_l;
  assign lo_l = lanes[LO_LANE*LANE_W +: LANE_W];
  assign hi_l = lanes[HI_LANE*LANE_W +: LANE_W];

  always_comb begin
    inc = '0;
    if (sel[SEL_W-1]) begin
      if (sel[SEL_W-2]) inc = {1'b0, hi_l[sel[2:0]]};
      else              inc = {1'b0, lo_l[sel[2:0]]};
    end else if (sel == '0) begin
      if (add_en) inc = {1'b0, lo_l[PAIR]} + {1'b0, lo_l[PAIR+4]};
    end else if (sel == SEL_OFF) begin
      inc = '0;
    end else if (sel == SEL_CYC) begin
      inc = 2'd1;
    end else begin
      inc = {1'b0, evt[sel[SEL_W-2:0]]};
    end
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTR_W-1:0] wdata,
  input  logic             run,
  input  inc_t             inc,
  output logic [CTR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (we)  q <= wdata;
    else if (run) q <= q + CTR_W'(inc);
  end
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_c0,
  input  logic                          wr_c1,
  input  logic                          wr_add,
  input  logic [REG_W-1:0]              wdata,
  input  logic                          any_msb,
  output logic [REG_W-1:0]              ctl0_q,
  output logic [REG_W-1:0]              ctl1_q,
  output logic [NUM_CTR-1:0]            add_en,
  output logic [NUM_CTR-1:0][SEL_W-1:0] sel,
  output logic                          irq_q
);
  logic [REG_W-1:0] ctl0_d;

  always_comb begin
    ctl0_d = wr_c0 ? wdata : ctl0_q;
    if (any_msb) ctl0_d[C0_OVF] = 1'b1;
    if (irq_q)   ctl0_d[C0_FRZ] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl0_q <= CTL0_RST;
      ctl1_q <= CTL1_RST;
      add_en <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctl0_q <= ctl0_d;
      irq_q  <= ctl0_q[C0_OVF] & ctl0_q[C0_IE];
      if (wr_c1)  ctl1_q <= wdata;
      if (wr_add) add_en <= wdata[NUM_CTR-1:0];
    end
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_sel
    if (k < 2) begin : g_c0
      assign sel[k] = ctl0_q[sel_pos(k) +: SEL_W];
    end else begin : g_c1
      assign sel[k] = ctl1_q[sel_pos(k) +: SEL_W];
    end
  end
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
  import pmu_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DIR_EVT-1:0]          evt_pulse,
  input  logic [NUM_LANES*LANE_W-1:0] bus_lanes,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  output logic                        pm_irq
);
  logic [REG_W-1:0]              ctl0_w, ctl1_w;
  logic [NUM_CTR-1:0]            add_en;
  logic [NUM_CTR-1:0][SEL_W-1:0] sel;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
  logic [NUM_CTR-1:0]            wr_ctr;
  logic                          any_msb;
  logic                          wr_c0, wr_c1, wr_add;
  logic [REG_W-1:0]              rd_mux;

  assign wr_c0  = reg_we && (reg_addr == ADDR_W'(0));
  assign wr_c1  = reg_we && (reg_addr == ADDR_W'(1));
  assign wr_add = reg_we && (reg_addr == ADDR_W'(2));

  always_comb begin
    any_msb = 1'b0;
    for (int k = 0; k < NUM_CTR; k++) any_msb = any_msb | ctr_q[k][CTR_W-1];
  end

  pmu_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_c0  (wr_c0),
    .wr_c1  (wr_c1),
    .wr_add (wr_add),
    .wdata  (reg_wdata),
    .any_msb(any_msb),
    .ctl0_q (ctl0_w),
    .ctl1_q (ctl1_w),
    .add_en (add_en),
    .sel    (sel),
    .irq_q  (pm_irq)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    inc_t inc;

    assign wr_ctr[k] = reg_we && reg_addr[ADDR_W-1] && (reg_addr[IDX_W-1:0] == IDX_W'(k));

    pmu_event_sel #(.CTR_IDX(k)) u_sel (
      .sel   (sel[k]),
      .add_en(add_en[k]),
      .evt   (evt_pulse),
      .lanes (bus_lanes),
      .inc   (inc)
    );

    pmu_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_ctr[k]),
      .wdata(reg_wdata[CTR_W-1:0]),
      .run  (!ctl0_w[C0_FRZ]),
      .inc  (inc),
      .q    (ctr_q[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr[ADDR_W-1]) begin
      rd_mux = REG_W'(ctr_q[reg_addr[IDX_W-1:0]]);
    end else begin
      case (reg_addr[IDX_W-1:0])
        IDX_W'(0): rd_mux = ctl0_w;
        IDX_W'(1): rd_mux = ctl1_w;
        IDX_W'(2): rd_mux = REG_W'(add_en);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk
  import pmu_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [REG_W-1:0]              ctl0,
  input logic                          msb_any,
  input logic                          reg_we,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic                          pm_irq,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q
);
  logic c0_wr;
  assign c0_wr = reg_we && (reg_addr == ADDR_W'(0));

  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl0[C0_FRZ] && !reg_we) |=> $stable(ctr_q));

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
    msb_any |=> ctl0[C0_OVF]);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl0[C0_OVF] && !c0_wr) |=> ctl0[C0_OVF]);

  p_ctl0_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!c0_wr && !msb_any && !pm_irq) |=> $stable(ctl0));

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl0[C0_OVF] && ctl0[C0_IE]) |=> pm_irq);

  p_irq_low_r10: assert property (@(posedge clk) disable iff (rst)
    !(ctl0[C0_OVF] && ctl0[C0_IE]) |=> !pm_irq);

  p_irq_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    pm_irq |=> ctl0[C0_FRZ]);
endmodule

bind pmu_bank pmu_bank_chk #(.CTR_W(CTR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctl0    (ctl0_w),
  .msb_any (any_msb),
  .reg_we  (reg_we),
  .reg_addr(reg_addr),
  .pm_irq  (pm_irq),
  .ctr_q   (ctr_q)
);

// File: tb/pmu_bank_test.sv
`timescale 1ns/1ps
module pmu_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt_pulse = '0;
  logic [31:0] bus_lanes = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pm_irq;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";
  int scan_i = 0;

  always #2.5 clk = ~clk;

  pmu_bank uut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_lanes(bus_lanes),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pm_irq(pm_irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_c0, m_c1, m_rd, m_ctr [8];
  logic [7:0]  m_add;
  bit          m_irq;
  logic [3:0]  m_raddr;

  function automatic int exp_inc(int k, logic [31:0] c0, logic [31:0] c1, logic [7:0] ad,
                                 logic [15:0] ev, logic [31:0] ln);
    int s, lo;
    if (k == 0)      s = int'((c0 >> 8) & 31);
    else if (k == 1) s = int'((c0 >> 1) & 31);
    else             s = int'((c1 >> (5 * (7 - k) + 2)) & 31);
    lo = (k == 0 || k == 1 || k == 4 || k == 5) ? 0 : 1;
    if (s >= 24) return int'((ln >> ((lo + 2) * 8 + s - 24)) & 1);
    if (s >= 16) return int'((ln >> (lo * 8 + s - 16)) & 1);
    if (s == 0) begin
      if (!ad[k]) return 0;
      return int'((ln >> (lo * 8 + k % 4)) & 1) + int'((ln >> (lo * 8 + k % 4 + 4)) & 1);
    end
    if (s == 8)  return 0;
    if (s == 15) return 1;
    return int'(ev[s]);
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    if (a >= 8) return m_ctr[a - 8];
    if (a == 0) return m_c0;
    if (a == 1) return m_c1;
    if (a == 2) return {24'h0, m_add};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_c0 = 32'h8000_0810; m_c1 = 32'h4210_8420; m_add = 8'h00;
      m_rd = 32'h0; m_irq = 1'b0; m_raddr = 4'h0;
      for (int k = 0; k < 8; k++) m_ctr[k] = 32'h0;
    end else begin
      logic [31:0] nc0;
      bit msb;
      bit frozen;
      m_rd = m_read(reg_addr);
      m_raddr = reg_addr;
      msb = 1'b0;
      for (int k = 0; k < 8; k++) if (m_ctr[k][31]) msb = 1'b1;
      frozen = m_c0[31];
      nc0 = (reg_we && reg_addr == 4'd0) ? reg_wdata : m_c0;
      if (msb)   nc0[0]  = 1'b1;
      if (m_irq) nc0[31] = 1'b1;
      for (int k = 0; k < 8; k++) begin
        if (reg_we && reg_addr == 4'(8 + k)) m_ctr[k] = reg_wdata;
        else if (!frozen) m_ctr[k] = m_ctr[k] + 32'(exp_inc(k, m_c0, m_c1, m_add, evt_pulse, bus_lanes));
      end
      m_irq = m_c0[0] & m_c0[30];
      m_c0 = nc0;
      if (reg_we && reg_addr == 4'd1) m_c1 = reg_wdata;
      if (reg_we && reg_addr == 4'd2) m_add = reg_wdata[7:0];
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (reg_rdata !== m_rd) begin
        fails++;
        $display("FAIL %s read addr %0d: got %h expected %h", cur_req, m_raddr, reg_rdata, m_rd);
      end
      checks++;
      if (pm_irq !== m_irq) begin
        fails++;
        $display("FAIL R10 irq: got %b expected %b", pm_irq, m_irq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] c0w(bit frz, bit ie, int s1, int s2);
    return (32'(frz) << 31) | (32'(ie) << 30) | (32'(s1) << 8) | (32'(s2) << 1);
  endfunction

  function automatic logic [31:0] c1w(int s3, int s4, int s5, int s6, int s7, int s8);
    return (32'(s3) << 27) | (32'(s4) << 22) | (32'(s5) << 17) |
           (32'(s6) << 12) | (32'(s7) << 7) | (32'(s8) << 2);
  endfunction

  task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d);
    @(posedge clk);
    #1;
    reg_we = we; reg_addr = a; reg_wdata = d;
    evt_pulse = 16'($urandom);
    bus_lanes = $urandom;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      int j;
      j = scan_i % 12;
      scan_i++;
      step(1'b0, 4'((j < 4) ? j : j + 4), 32'h0);
    end
  endtask

  initial begin
    #500000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    cmp_on = 1'b1;
    // R1: reset values on every address
    cur_req = "R1";
    idle(13);
    // R2: selector 0x08 unfrozen, nothing moves
    cur_req = "R2";
    step(1, 0, c0w(0, 0, 8, 8));
    idle(24);
    // R3: cycle counting on counters 1 and 3
    cur_req = "R3";
    step(1, 0, c0w(0, 0, 15, 8));
    step(1, 1, c1w(15, 8, 8, 8, 8, 8));
    idle(24);
    // R4: direct events incl. completed instructions (index 9)
    cur_req = "R4";
    step(1, 0, c0w(0, 0, 15, 9));
    step(1, 1, c1w(3, 14, 1, 7, 10, 12));
    idle(36);
    // R5: bus bits, lower and upper lanes of both lane groups
    cur_req = "R5";
    step(1, 0, c0w(0, 0, 24 + 3, 16 + 1));
    step(1, 1, c1w(16 + 2, 24 + 5, 16 + 7, 24 + 0, 16 + 0, 24 + 7));
    idle(36);
    // R6: adder mode on all counters
    cur_req = "R6";
    step(1, 2, 32'hFF);
    step(1, 0, c0w(0, 0, 0, 0));
    step(1, 1, c1w(0, 0, 0, 0, 0, 0));
    idle(36);
    // R7: adder disabled for counters 5..8 while selector is 0
    cur_req = "R7";
    step(1, 2, 32'h0F);
    idle(24);
    // R8: writes override increments
    cur_req = "R8";
    step(1, 0, c0w(0, 0, 15, 15));
    step(1, 8, 32'd100);
    step(1, 9, 32'h55);
    step(1, 8, 32'd7);
    step(1, 12, 32'h1234);
    idle(12);
    // R2: freeze holds all counters
    cur_req = "R2";
    step(1, 0, c0w(1, 0, 15, 15));
    idle(24);
    // R9: overflow sticky, clear only once no top bit is set
    cur_req = "R9";
    step(1, 0, c0w(0, 0, 15, 8));
    step(1, 8, 32'h7FFF_FFFC);
    idle(12);
    step(1, 0, c0w(0, 0, 15, 8));
    idle(4);
    step(1, 8, 32'h0);
    step(1, 0, c0w(0, 0, 15, 8));
    idle(12);
    // R10: interrupt and self-freeze
    cur_req = "R10";
    step(1, 8, 32'h7FFF_FFFE);
    step(1, 0, c0w(0, 1, 15, 8));
    idle(24);
    step(1, 0, c0w(0, 1, 15, 8));
    idle(6);
    step(1, 8, 32'h0);
    step(1, 0, c0w(0, 0, 15, 8));
    idle(12);
    // R11: unmapped addresses read zero, read latency one cycle
    cur_req = "R11";
    step(0, 3, 0); step(0, 5, 0); step(0, 7, 0); step(0, 6, 0);
    idle(13);
    @(posedge clk);
    #1;
    @(negedge clk);
    #1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule